// File: doc/BRIEF.md
# Accumulator ALU with status flags

This block is the arithmetic and logic datapath of an 8-bit accumulator machine. Each cycle it takes the accumulator byte, a second operand byte and a 5-bit operation code. In the same cycle it presents the result byte, the candidate value of every status flag and a per-flag update mask. The carry that the with-carry operations and the rotates through carry consume comes from the block's own registered flag word. When `exec_en` is high, a clock edge writes into that word exactly the flags that the operation is allowed to change.

The operations are: add and subtract, each with and without carry; increment and decrement by one; AND, OR and XOR; compare; complement; four rotates; and set or complement carry. Every operation class has its own rule for which flags change. One shared adder produces the sum, the carry or borrow out of the top bit, and the carry or borrow out of bit 3. The surrounding control logic writes `result_o` back to whichever register it chooses. Unused operation codes pass the accumulator through and change no flag.

Top module: `acc_alu`

## Requirements
- R1: The flag word has five bits: bit 0 carry (CY), bit 1 parity (P), bit 2 half carry (AC), bit 3 zero (Z) and bit 4 sign (S). For ADD (code 0) the result is acc+opnd, and for ADC (code 1) it is acc+opnd+CY. CY becomes 1 when the unsigned sum exceeds 8 bits.
- R2: For SUB (code 2) the result is acc-opnd, and for SBB (code 3) it is acc-opnd-CY, both modulo 256. The subtraction uses the two's complement of the operand with the adder carry inverted, so CY becomes 1 exactly when a borrow occurs.
- R3: For add, subtract, compare, increment and decrement, AC is the carry out of bit 3. For the subtracting forms it is the borrow into bit 4.
- R4: INC (code 4) returns opnd+1 and DEC (code 5) returns opnd-1. Both update S, Z, AC and P and leave CY untouched (update mask 5'b11110).
- R5: AND (code 6), OR (code 7) and XOR (code 8) return the bitwise result and update all five flags. AND forces AC=1 and CY=0. OR and XOR force AC=0 and CY=0.
- R6: CMA (code 10) returns the inverse of acc and updates no flag.
- R7: CMP (code 9) returns acc unchanged. Its flags are those that SUB would produce for the same operands.
- R8: RLC (code 11) rotates acc left, with bit 7 going to bit 0 and to CY. RRC (code 12) rotates right, with bit 0 going to bit 7 and to CY. Only CY is updated.
- R9: RAL (code 13) shifts acc left, moving the old CY into bit 0 and bit 7 into CY. RAR (code 14) shifts acc right, moving the old CY into bit 7 and bit 0 into CY. Only CY is updated.
- R10: STC (code 15) sets CY to 1 and CMC (code 16) inverts CY. Both return acc and update no other flag.
- R11: Whenever S, Z and P are updated, S is bit 7 of the flag source, Z is 1 when the source is zero, and P is 1 when the source has an even number of ones. The flag source is the result, or the difference for CMP.
- R12: The flag word resets to 0. A clock edge with `exec_en` high writes only the masked flags. With `exec_en` low the flag word holds.
- R13: Codes 17 to 31 return acc and update no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| exec_en | input | 1 | Commit the masked flag updates at this clock edge |
| op_i | input | 5 | Operation code |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand (the subject of increment and decrement) |
| result_o | output | 8 | Result byte |
| flag_nxt_o | output | 5 | Candidate flag values {S,Z,AC,P,CY} |
| flag_upd_o | output | 5 | Per-flag update mask |
| flags_o | output | 5 | Registered flag word |

## Verification
A wrong operation decode or adder control shows on `result_o`, `flag_nxt_o` or `flag_upd_o` in the same cycle the code is applied, because the datapath has no register in it. A corrupted or wrongly masked flag bit shows on `flags_o` one edge later. It also feeds into the next with-carry operation or rotate through carry, so a stale CY appears again there as a wrong result. The reset synchronizer delays the first write to the flag word by two edges after `rst_n` rises.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int FLAG_W = 5;
  localparam int FL_CY  = 0;
  localparam int FL_P   = 1;
  localparam int FL_AC  = 2;
  localparam int FL_Z   = 3;
  localparam int FL_S   = 4;

  localparam logic [FLAG_W-1:0] UPD_ALL   = 5'b11111;
  localparam logic [FLAG_W-1:0] UPD_NO_CY = 5'b11110;
  localparam logic [FLAG_W-1:0] UPD_CY    = 5'b00001;
  localparam logic [FLAG_W-1:0] UPD_NONE  = 5'b00000;

  typedef enum logic [4:0] {
    OP_ADD = 5'd0,
    OP_ADC = 5'd1,
    OP_SUB = 5'd2,
    OP_SBB = 5'd3,
    OP_INC = 5'd4,
    OP_DEC = 5'd5,
    OP_AND = 5'd6,
    OP_OR  = 5'd7,
    OP_XOR = 5'd8,
    OP_CMP = 5'd9,
    OP_CMA = 5'd10,
    OP_RLC = 5'd11,
    OP_RRC = 5'd12,
    OP_RAL = 5'd13,
    OP_RAR = 5'd14,
    OP_STC = 5'd15,
    OP_CMC = 5'd16
  } alu_op_e;

endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int DATA_W = 8,
  parameter int LOW_W  = 4
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o,
  output logic              half_o
);
  localparam int HI_W = DATA_W - LOW_W;

  logic [DATA_W-1:0] b_eff;
  logic              c0;
  logic [LOW_W:0]    low_sum;
  logic [HI_W:0]     high_sum;

  // Subtraction: add the inverted operand with an inverted borrow-in,
  // then invert both carries so that they read as borrows.
  always_comb begin
    b_eff    = sub_i ? ~b_i : b_i;
    c0       = sub_i ? ~cin_i : cin_i;
    low_sum  = {1'b0, a_i[LOW_W-1:0]} + {1'b0, b_eff[LOW_W-1:0]}
             + {{LOW_W{1'b0}}, c0};
    high_sum = {1'b0, a_i[DATA_W-1:LOW_W]} + {1'b0, b_eff[DATA_W-1:LOW_W]}
             + {{HI_W{1'b0}}, low_sum[LOW_W]};
    sum_o    = {high_sum[HI_W-1:0], low_sum[LOW_W-1:0]};
    cout_o   = high_sum[HI_W] ^ sub_i;
    half_o   = low_sum[LOW_W] ^ sub_i;
  end

endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cy_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cy_o
);
  localparam int MSB = DATA_W - 1;

  always_comb begin
    res_o = a_i;
    cy_o  = cy_i;
    unique case (op_i)
      OP_AND: res_o = a_i & b_i;
      OP_OR:  res_o = a_i | b_i;
      OP_XOR: res_o = a_i ^ b_i;
      OP_CMA: res_o = ~a_i;
      OP_RLC: begin
        res_o = {a_i[MSB-1:0], a_i[MSB]};
        cy_o  = a_i[MSB];
      end
      OP_RRC: begin
        res_o = {a_i[0], a_i[MSB:1]};
        cy_o  = a_i[0];
      end
      OP_RAL: begin
        res_o = {a_i[MSB-1:0], cy_i};
        cy_o  = a_i[MSB];
      end
      OP_RAR: begin
        res_o = {cy_i, a_i[MSB:1]};
        cy_o  = a_i[0];
      end
      OP_STC: cy_o = 1'b1;
      OP_CMC: cy_o = ~cy_i;
      default: begin
        res_o = a_i;
        cy_o  = cy_i;
      end
    endcase
  end

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import acc_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [FLAG_W-1:0] upd_i,
  input  logic [FLAG_W-1:0] nxt_i,
  output logic [FLAG_W-1:0] flags_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [FLAG_W-1:0] flags_d;
  logic [FLAG_W-1:0] flags_q;

  // Asserted asynchronously, released after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
    always_comb begin
      if (en_i && upd_i[i]) flags_d[i] = nxt_i[i];
      else                  flags_d[i] = flags_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) flags_q <= '0;
    else            flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  // R12: idle cycles leave the word alone
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    !en_i |=> $stable(flags_q));
  // R12: unmasked bits keep their value through a committed operation
  a_r12_masked_keep: assert property (@(posedge clk) disable iff (!rst_int_n)
    en_i |=> (((flags_q ^ $past(flags_q)) & ~$past(upd_i)) == '0));
  // R12: masked bits take the candidate value
  a_r12_load: assert property (@(posedge clk) disable iff (!rst_int_n)
    en_i |=> ((flags_q & $past(upd_i)) == ($past(nxt_i) & $past(upd_i))));

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_en,
  input  logic [4:0]        op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  output logic [DATA_W-1:0] result_o,
  output logic [FLAG_W-1:0] flag_nxt_o,
  output logic [FLAG_W-1:0] flag_upd_o,
  output logic [FLAG_W-1:0] flags_o
);
  localparam int LOW_W = DATA_W / 2;

  alu_op_e           op;
  logic [DATA_W-1:0] add_a, add_b, add_sum;
  logic              add_sub, add_cin, add_cout, add_half;
  logic [DATA_W-1:0] lg_res;
  logic              lg_cy;
  logic              cy_q;
  logic [DATA_W-1:0] fsrc;
  logic              ac_v, cy_v;

  assign op   = alu_op_e'(op_i);
  assign cy_q = flags_o[FL_CY];

  // Adder operand steering
  always_comb begin
    add_a   = acc_i;
    add_b   = opnd_i;
    add_sub = 1'b0;
    add_cin = 1'b0;
    unique case (op)
      OP_ADC: add_cin = cy_q;
      OP_SUB, OP_CMP: add_sub = 1'b1;
      OP_SBB: begin
        add_sub = 1'b1;
        add_cin = cy_q;
      end
      OP_INC: begin
        add_a   = opnd_i;
        add_b   = '0;
        add_cin = 1'b1;
      end
      OP_DEC: begin
        add_a   = opnd_i;
        add_b   = DATA_W'(1);
        add_sub = 1'b1;
      end
      default: ;
    endcase
  end

  alu_adder #(.DATA_W(DATA_W), .LOW_W(LOW_W)) u_adder (
    .a_i   (add_a),
    .b_i   (add_b),
    .sub_i (add_sub),
    .cin_i (add_cin),
    .sum_o (add_sum),
    .cout_o(add_cout),
    .half_o(add_half)
  );

  alu_logic #(.DATA_W(DATA_W)) u_logic (
    .op_i (op),
    .a_i  (acc_i),
    .b_i  (opnd_i),
    .cy_i (cy_q),
    .res_o(lg_res),
    .cy_o (lg_cy)
  );

  // Result select and per-class flag policy
  always_comb begin
    result_o   = acc_i;
    fsrc       = lg_res;
    flag_upd_o = UPD_NONE;
    ac_v       = 1'b0;
    cy_v       = lg_cy;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
        result_o   = add_sum;
        fsrc       = add_sum;
        ac_v       = add_half;
        cy_v       = add_cout;
        flag_upd_o = UPD_ALL;
      end
      OP_CMP: begin
        result_o   = acc_i;
        fsrc       = add_sum;
        ac_v       = add_half;
        cy_v       = add_cout;
        flag_upd_o = UPD_ALL;
      end
      OP_INC, OP_DEC: begin
        result_o   = add_sum;
        fsrc       = add_sum;
        ac_v       = add_half;
        cy_v       = cy_q;
        flag_upd_o = UPD_NO_CY;
      end
      OP_AND: begin
        result_o   = lg_res;
        ac_v       = 1'b1;
        cy_v       = 1'b0;
        flag_upd_o = UPD_ALL;
      end
      OP_OR, OP_XOR: begin
        result_o   = lg_res;
        ac_v       = 1'b0;
        cy_v       = 1'b0;
        flag_upd_o = UPD_ALL;
      end
      OP_CMA: result_o = lg_res;
      OP_RLC, OP_RRC, OP_RAL, OP_RAR, OP_STC, OP_CMC: begin
        result_o   = lg_res;
        flag_upd_o = UPD_CY;
      end
      default: result_o = acc_i;
    endcase
    flag_nxt_o[FL_S]  = fsrc[DATA_W-1];
    flag_nxt_o[FL_Z]  = (fsrc == '0);
    flag_nxt_o[FL_AC] = ac_v;
    flag_nxt_o[FL_P]  = ~^fsrc;
    flag_nxt_o[FL_CY] = cy_v;
  end

  alu_flag_reg u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (exec_en),
    .upd_i  (flag_upd_o),
    .nxt_i  (flag_nxt_o),
    .flags_o(flags_o)
  );

  // R4: increment and decrement never touch carry
  a_r4_incdec_keep_cy: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_INC || op_i == OP_DEC) |-> !flag_upd_o[FL_CY]);
  // R5: AND forces the half carry high and the carry low
  a_r5_and_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_AND) |-> (flag_nxt_o[FL_AC] && !flag_nxt_o[FL_CY]));
  // R6: complement changes no flag
  a_r6_cma_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_CMA) |-> (flag_upd_o == '0));
  // R7: compare hands back the accumulator
  a_r7_cmp_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_CMP) |-> (result_o == acc_i));
  // R8: rotates touch carry only
  a_r8_rot_cy_only: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i >= OP_RLC && op_i <= OP_RAR) |-> ($countones(flag_upd_o) == 1 && flag_upd_o[FL_CY]));
  // R11: zero flag agrees with the result byte
  a_r11_zero_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_upd_o[FL_Z] && op_i != OP_CMP) |-> (flag_nxt_o[FL_Z] == (result_o == '0)));
  // R13: unassigned codes are inert
  a_r13_unused_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i > OP_CMC) |-> (flag_upd_o == '0 && result_o == acc_i));

endmodule

// File: tb/tb_acc_alu.sv
module tb_acc_alu;
  import acc_alu_pkg::*;

  logic       clk, rst_n, exec_en;
  logic [4:0] op_i;
  logic [7:0] acc_i, opnd_i, result_o;
  logic [4:0] flag_nxt_o, flag_upd_o, flags_o;

  int n_chk, n_fail;
  logic [4:0] model_fl;

  acc_alu dut (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op_i(op_i),
    .acc_i(acc_i), .opnd_i(opnd_i), .result_o(result_o),
    .flag_nxt_o(flag_nxt_o), .flag_upd_o(flag_upd_o), .flags_o(flags_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic [4:0] op;
    logic [7:0] a;
    logic [7:0] b;
    logic       cy;
    logic [7:0] res;
    logic [4:0] upd;
    logic [4:0] nxt;
  } vec_t;

  // nxt is given for the updated bits only, order {S,Z,AC,P,CY}
  localparam int NVEC = 19;
  localparam vec_t VECS [NVEC] = '{
    '{5'd0,  8'h7F, 8'h01, 1'b0, 8'h80, 5'b11111, 5'b10100},
    '{5'd1,  8'hFF, 8'h00, 1'b1, 8'h00, 5'b11111, 5'b01111},
    '{5'd0,  8'hFF, 8'h01, 1'b1, 8'h00, 5'b11111, 5'b01111},
    '{5'd2,  8'h00, 8'h01, 1'b0, 8'hFF, 5'b11111, 5'b10111},
    '{5'd3,  8'h80, 8'h7F, 1'b1, 8'h00, 5'b11111, 5'b01110},
    '{5'd9,  8'h05, 8'h05, 1'b0, 8'h05, 5'b11111, 5'b01010},
    '{5'd4,  8'h33, 8'hFF, 1'b1, 8'h00, 5'b11110, 5'b01110},
    '{5'd5,  8'h33, 8'h00, 1'b0, 8'hFF, 5'b11110, 5'b10110},
    '{5'd6,  8'hF0, 8'h3C, 1'b1, 8'h30, 5'b11111, 5'b00110},
    '{5'd7,  8'h80, 8'h00, 1'b1, 8'h80, 5'b11111, 5'b10000},
    '{5'd8,  8'hFF, 8'hFF, 1'b1, 8'h00, 5'b11111, 5'b01010},
    '{5'd10, 8'h7F, 8'h00, 1'b1, 8'h80, 5'b00000, 5'b00000},
    '{5'd11, 8'h80, 8'h00, 1'b0, 8'h01, 5'b00001, 5'b00001},
    '{5'd12, 8'h01, 8'h00, 1'b0, 8'h80, 5'b00001, 5'b00001},
    '{5'd13, 8'h80, 8'h00, 1'b0, 8'h00, 5'b00001, 5'b00001},
    '{5'd14, 8'h00, 8'h00, 1'b1, 8'h80, 5'b00001, 5'b00000},
    '{5'd15, 8'h7F, 8'h00, 1'b0, 8'h7F, 5'b00001, 5'b00001},
    '{5'd16, 8'h7F, 8'h00, 1'b1, 8'h7F, 5'b00001, 5'b00000},
    '{5'd31, 8'h5A, 8'h11, 1'b1, 8'h5A, 5'b00000, 5'b00000}
  };

  function automatic string req_of(input logic [4:0] op);
    case (op)
      5'd0, 5'd1:               return "R1";
      5'd2, 5'd3:               return "R2";
      5'd4, 5'd5:               return "R4";
      5'd6, 5'd7, 5'd8:         return "R5";
      5'd9:                     return "R7";
      5'd10:                    return "R6";
      5'd11, 5'd12:             return "R8";
      5'd13, 5'd14:             return "R9";
      5'd15, 5'd16:             return "R10";
      default:                  return "R13";
    endcase
  endfunction

  function automatic logic [7:0] corner(input int i);
    case (i)
      0: return 8'h00;
      1: return 8'hFF;
      2: return 8'h7F;
      default: return 8'h80;
    endcase
  endfunction

  // Independent reference built from the requirements
  task automatic ref_alu(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic cy, output logic [7:0] res, output logic [4:0] upd,
                         output logic [4:0] nxt);
    int s, ci;
    logic [7:0] v;
    logic ac, c;
    res = a; upd = 5'b0; v = a; ac = 1'b0; c = cy;
    case (op)
      5'd0, 5'd1: begin
        ci  = (op == 5'd1) ? int'(cy) : 0;
        s   = int'(a) + int'(b) + ci;
        v   = 8'(s); res = v; c = (s > 255);
        ac  = (int'(a[3:0]) + int'(b[3:0]) + ci) > 15;
        upd = 5'b11111;
      end
      5'd2, 5'd3, 5'd9: begin
        ci  = (op == 5'd3) ? int'(cy) : 0;
        s   = int'(a) - int'(b) - ci;
        v   = 8'(s); c = (s < 0);
        ac  = (int'(a[3:0]) - int'(b[3:0]) - ci) < 0;
        res = (op == 5'd9) ? a : v;
        upd = 5'b11111;
      end
      5'd4: begin v = 8'(int'(b) + 1); res = v; ac = (b[3:0] == 4'hF); upd = 5'b11110; end
      5'd5: begin v = 8'(int'(b) - 1); res = v; ac = (b[3:0] == 4'h0); upd = 5'b11110; end
      5'd6: begin v = a & b; res = v; ac = 1'b1; c = 1'b0; upd = 5'b11111; end
      5'd7: begin v = a | b; res = v; c = 1'b0; upd = 5'b11111; end
      5'd8: begin v = a ^ b; res = v; c = 1'b0; upd = 5'b11111; end
      5'd10: res = ~a;
      5'd11: begin res = {a[6:0], a[7]}; c = a[7]; upd = 5'b00001; end
      5'd12: begin res = {a[0], a[7:1]}; c = a[0]; upd = 5'b00001; end
      5'd13: begin res = {a[6:0], cy};   c = a[7]; upd = 5'b00001; end
      5'd14: begin res = {cy, a[7:1]};   c = a[0]; upd = 5'b00001; end
      5'd15: begin c = 1'b1; upd = 5'b00001; end
      5'd16: begin c = ~cy;  upd = 5'b00001; end
      default: ;
    endcase
    nxt = {v[7], (v == 8'h00), ac, ~^v, c};
  endtask

  task automatic chk(input string req, input string what, input logic [7:0] act,
                     input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic en);
    @(negedge clk);
    op_i = op; acc_i = a; opnd_i = b; exec_en = en;
  endtask

  task automatic set_cy(input logic v);
    drive(5'd15, 8'h00, 8'h00, 1'b1);
    if (!v) drive(5'd16, 8'h00, 8'h00, 1'b1);
    @(posedge clk);
    model_fl[0] = v;
  endtask

  task automatic apply(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic cy, input logic [7:0] e_res, input logic [4:0] e_upd,
                       input logic [4:0] e_nxt);
    string r;
    r = req_of(op);
    set_cy(cy);
    drive(op, a, b, 1'b1);
    #2;
    chk(r, "result", result_o, e_res);
    chk(r, "update mask", {3'b0, flag_upd_o}, {3'b0, e_upd});
    chk({r, " R3/R11"}, "flag values", {3'b0, flag_nxt_o & e_upd}, {3'b0, e_nxt & e_upd});
    model_fl = (model_fl & ~e_upd) | (e_nxt & e_upd);
    @(posedge clk);
    #1;
    chk("R12", "flag word", {3'b0, flags_o}, {3'b0, model_fl});
  endtask

  task automatic apply_ref(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                           input logic cy);
    logic [7:0] er;
    logic [4:0] eu, en;
    ref_alu(op, a, b, cy, er, eu, en);
    apply(op, a, b, cy, er, eu, en);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual still running, expected finished");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; exec_en = 1'b0; op_i = 5'd0; acc_i = 8'h00; opnd_i = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    chk("R12", "reset flag word", {3'b0, flags_o}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    model_fl = 5'b0;

    // table of directed vectors
    for (int i = 0; i < NVEC; i++)
      apply(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].cy,
            VECS[i].res, VECS[i].upd, VECS[i].nxt);

    // R12: no commit without exec_en
    set_cy(1'b1);
    drive(5'd0, 8'h01, 8'h02, 1'b0);
    @(posedge clk);
    #1;
    chk("R12", "hold without exec_en", {3'b0, flags_o}, {3'b0, model_fl});

    // corner operands against the reference, both carry states
    for (int op = 0; op <= 16; op++)
      for (int ia = 0; ia < 4; ia++)
        for (int ib = 0; ib < 4; ib++)
          for (int c = 0; c < 2; c++)
            apply_ref(5'(op), corner(ia), corner(ib), c[0]);

    // random operands against the reference, including an unused code (R13)
    for (int k = 0; k < 400; k++) begin
      int r;
      r = $urandom_range(18, 0);
      apply_ref((r == 18) ? 5'd23 : 5'(r), 8'($urandom), 8'($urandom), 1'($urandom));
    end

    @(negedge clk);
    exec_en = 1'b0;
    finish_run();
  end

endmodule